// File: doc/BRIEF.md
# Complementary Dead-Band Inserter

This block sits between a PWM generator and the gate-drive pins. It takes the generator's two raw PWM signals. In bypass mode it forwards them one clock later. In dead-band mode it drops the second signal and builds a complementary pair from the first one.

In dead-band mode, the high-side output follows the input but rises only after a programmable number of clocks. The low-side output is the inverse of the input and rises only after a second programmable number of clocks has passed since the input fell. Each output falls one clock after its source goes inactive, so the two sides never conduct at the same time. A pulse shorter than the delay that applies to it never reaches the output.

Two conditioning steps follow, each set per output. A fault mask forces a selected output to its inactive (low) level for as long as the fault input is high. A final inversion then makes an output active low.

Top module: `deadband_inserter`

## Requirements
- R1: With `db_en_i` low, `out_hi_o` equals `pwm_a_i` and `out_lo_o` equals `pwm_b_i` as sampled one clock earlier (no fault, no inversion).
- R2: With `db_en_i` high, `pwm_b_i` has no effect on either output.
- R3: With `db_en_i` high, `out_hi_o` rises `rise_dly_i`+1 clocks after `pwm_a_i` rises and falls one clock after `pwm_a_i` falls. This holds for every value from 0 up to 4095.
- R4: With `db_en_i` high, `out_lo_o` rises `fall_dly_i`+1 clocks after `pwm_a_i` falls and falls one clock after `pwm_a_i` rises.
- R5: A delay value of zero adds no delay beyond the one-clock pipeline latency.
- R6: If `pwm_a_i` stays high for fewer clocks than `rise_dly_i`+1, `out_hi_o` stays low for that whole pulse.
- R7: While `fault_i` is high, each output whose bit in `fault_mask_i` is set (bit 0 = high side, bit 1 = low side) goes at once to its inactive level. An output whose bit is clear is unaffected.
- R8: Bit 0 / bit 1 of `invert_i` invert `out_hi_o` / `out_lo_o` after fault forcing, so a faulted inverted output reads 1.
- R9: In dead-band mode, the high-side and low-side signals before conditioning are never both high.
- R10: While `rst_n` is low, both outputs sit at their inactive level, so each pin equals its `invert_i` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; delays count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_a_i | input | 1 | First raw PWM signal |
| pwm_b_i | input | 1 | Second raw PWM signal (bypass mode only) |
| db_en_i | input | 1 | 1 = dead-band mode, 0 = bypass |
| rise_dly_i | input | DLY_W | High-side rising-edge delay in clocks |
| fall_dly_i | input | DLY_W | Low-side rising-edge delay in clocks |
| fault_i | input | 1 | Fault condition, active high |
| fault_mask_i | input | 2 | Per-output fault enable (bit0 high side, bit1 low side) |
| invert_i | input | 2 | Per-output final inversion (bit0 high side, bit1 low side) |
| out_hi_o | output | 1 | High-side output |
| out_lo_o | output | 1 | Low-side output |

## Verification
The bench builds the block with the default 12-bit delay width. This lets it set a rise delay of 4095, the largest value, and check that the edge arrives exactly 4096 clocks after the input edge. It also covers small delays of 0, 1, 3 and 7 clocks, where off-by-one errors in the saturating run counter would show up. A 5-clock delay applied to a 3-clock pulse shows the pulse being swallowed.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

    localparam int NUM_SIDES = 2;
    localparam int SIDE_HI   = 0;
    localparam int SIDE_LO   = 1;

    typedef logic [NUM_SIDES-1:0] side_vec_t;

    typedef struct packed {
        logic a;
        logic b;
        logic en;
    } raw_state_t;

endpackage

// File: rtl/dbi_edge_delay.sv
// Delays the rising edge of x_i by dly_i clocks; the falling edge passes
// after the one-clock register stage.
module dbi_edge_delay #(
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             x_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             y_o
);

    typedef struct packed {
        logic [DLY_W-1:0] run;
        logic             y;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!x_i) begin
            st_d.run = '0;
            st_d.y   = 1'b0;
        end else begin
            st_d.y = (st_q.run >= dly_i);
            if (st_q.run < dly_i) begin
                st_d.run = st_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_o = st_q.y;

    // R3: an inactive input drops the output on the next clock
    assert_fall_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !x_i |=> !y_o);

    // R3: once high, the output holds while input and delay are steady
    assert_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (x_i && y_o && $stable(dly_i)) |=> y_o);

endmodule

// File: rtl/dbi_out_stage.sv
// Per-side fault forcing followed by polarity inversion.
module dbi_out_stage
    import dbi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  side_vec_t pre_i,
    input  logic      fault_i,
    input  side_vec_t fmask_i,
    input  side_vec_t inv_i,
    output side_vec_t pin_o
);

    side_vec_t gated;

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        always_comb begin
            gated[g] = pre_i[g] & ~(fault_i & fmask_i[g]);
            pin_o[g] = gated[g] ^ inv_i[g];
        end

        // R7: a masked fault leaves the pin at its inactive polarity
        assert_fault_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_i && fmask_i[g]) |-> (pin_o[g] == inv_i[g]));

        // R8: without a masked fault the pin is the source with optional inversion
        assert_polarity_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(fault_i && fmask_i[g]) |-> (pin_o[g] == (pre_i[g] ^ inv_i[g])));
    end

endmodule

// File: rtl/deadband_inserter.sv
module deadband_inserter
    import dbi_pkg::*;
#(
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_a_i,
    input  logic             pwm_b_i,
    input  logic             db_en_i,
    input  logic [DLY_W-1:0] rise_dly_i,
    input  logic [DLY_W-1:0] fall_dly_i,
    input  logic             fault_i,
    input  logic [1:0]       fault_mask_i,
    input  logic [1:0]       invert_i,
    output logic             out_hi_o,
    output logic             out_lo_o
);

    raw_state_t raw_d, raw_q;
    logic       hi_dly, lo_dly;
    side_vec_t  pre, pins;

    always_comb begin
        raw_d    = raw_q;
        raw_d.a  = pwm_a_i;
        raw_d.b  = pwm_b_i;
        raw_d.en = db_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= raw_d;
        end
    end

    dbi_edge_delay #(.DLY_W(DLY_W)) u_hi_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .x_i   (pwm_a_i),
        .dly_i (rise_dly_i),
        .y_o   (hi_dly)
    );

    dbi_edge_delay #(.DLY_W(DLY_W)) u_lo_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .x_i   (~pwm_a_i),
        .dly_i (fall_dly_i),
        .y_o   (lo_dly)
    );

    always_comb begin
        pre[SIDE_HI] = raw_q.en ? hi_dly : raw_q.a;
        pre[SIDE_LO] = raw_q.en ? lo_dly : raw_q.b;
    end

    dbi_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_i   (pre),
        .fault_i (fault_i),
        .fmask_i (fault_mask_i),
        .inv_i   (invert_i),
        .pin_o   (pins)
    );

    assign out_hi_o = pins[SIDE_HI];
    assign out_lo_o = pins[SIDE_LO];

    // R9: the two delayed sides never overlap
    assert_nonoverlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_dly && lo_dly));

    // R2: in dead-band mode the low side comes only from the delay path
    assert_b_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        raw_q.en |-> (pre[SIDE_LO] == lo_dly));

endmodule

// File: tb/deadband_inserter_bench.sv
module deadband_inserter_bench;

    localparam int DLY_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwm_a = 1'b0, pwm_b = 1'b0, db_en = 1'b0, fault = 1'b0;
    logic [DLY_W-1:0] rise_dly = '0, fall_dly = '0;
    logic [1:0]       fmask = 2'b00, inv = 2'b00;
    logic             out_hi, out_lo;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    deadband_inserter #(.DLY_W(DLY_W)) u_deadband_inserter (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwm_a_i      (pwm_a),
        .pwm_b_i      (pwm_b),
        .db_en_i      (db_en),
        .rise_dly_i   (rise_dly),
        .fall_dly_i   (fall_dly),
        .fault_i      (fault),
        .fault_mask_i (fmask),
        .invert_i     (inv),
        .out_hi_o     (out_hi),
        .out_lo_o     (out_lo)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        step(int'(rise_dly) + int'(fall_dly) + 4);
    endtask

    task automatic t_reset();
        inv = 2'b11; #1;
        check("R10 hi inverted in reset", out_hi, 1'b1);
        check("R10 lo inverted in reset", out_lo, 1'b1);
        inv = 2'b00; #1;
        check("R10 hi in reset", out_hi, 1'b0);
        check("R10 lo in reset", out_lo, 1'b0);
    endtask

    task automatic t_bypass();
        db_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            pwm_a = i[0]; pwm_b = i[1];
            step(1);
            check("R1 bypass hi", out_hi, i[0]);
            check("R1 bypass lo", out_lo, i[1]);
        end
    endtask

    task automatic t_ignore_b();
        db_en = 1'b1; rise_dly = 12'd2; fall_dly = 12'd2; pwm_a = 1'b0;
        settle();
        for (int i = 0; i < 6; i++) begin
            pwm_b = ~pwm_b;
            step(1);
            check("R2 b ignored hi", out_hi, 1'b0);
            check("R2 b ignored lo", out_lo, 1'b1);
        end
        pwm_b = 1'b0;
    endtask

    task automatic t_rise(input int d);
        db_en = 1'b1; rise_dly = d[DLY_W-1:0]; fall_dly = 12'd1; pwm_a = 1'b0;
        settle();
        pwm_a = 1'b1;
        step(1);
        check("R4 lo falls one clock after rise", out_lo, 1'b0);
        check("R3 hi after one clock", out_hi, d == 0);
        if (d > 0) begin
            step(d - 1);
            check("R3 hi still low before delay", out_hi, 1'b0);
            step(1);
            check("R3 hi rises at delay+1", out_hi, 1'b1);
        end
    endtask

    task automatic t_fall(input int f);
        db_en = 1'b1; fall_dly = f[DLY_W-1:0]; rise_dly = 12'd1; pwm_a = 1'b1;
        settle();
        pwm_a = 1'b0;
        step(1);
        check("R3 hi falls one clock after fall", out_hi, 1'b0);
        check("R4 lo after one clock", out_lo, f == 0);
        if (f > 0) begin
            step(f - 1);
            check("R4 lo still low before delay", out_lo, 1'b0);
            step(1);
            check("R4 lo rises at delay+1", out_lo, 1'b1);
        end
    endtask

    task automatic t_zero();
        db_en = 1'b1; rise_dly = '0; fall_dly = '0; pwm_a = 1'b0;
        settle();
        for (int i = 0; i < 4; i++) begin
            pwm_a = ~pwm_a;
            step(1);
            check("R5 zero delay hi", out_hi, pwm_a);
            check("R5 zero delay lo", out_lo, ~pwm_a);
        end
    endtask

    task automatic t_short();
        bit seen = 1'b0;
        db_en = 1'b1; rise_dly = 12'd5; fall_dly = 12'd0; pwm_a = 1'b0;
        settle();
        pwm_a = 1'b1;
        for (int i = 0; i < 12; i++) begin
            if (i == 3) pwm_a = 1'b0;
            step(1);
            if (out_hi) seen = 1'b1;
        end
        check("R6 short pulse swallowed", seen, 1'b0);
    endtask

    task automatic t_fault();
        db_en = 1'b0; pwm_a = 1'b1; pwm_b = 1'b1; inv = 2'b00;
        step(2);
        fmask = 2'b01; fault = 1'b1; #1;
        check("R7 masked hi forced", out_hi, 1'b0);
        check("R7 unmasked lo kept", out_lo, 1'b1);
        fmask = 2'b10; #1;
        check("R7 masked lo forced", out_lo, 1'b0);
        check("R7 unmasked hi kept", out_hi, 1'b1);
        fault = 1'b0; #1;
        check("R7 release lo", out_lo, 1'b1);
        fmask = 2'b00;
    endtask

    task automatic t_invert();
        db_en = 1'b0; pwm_a = 1'b1; pwm_b = 1'b0; inv = 2'b11;
        step(1);
        check("R8 inverted hi", out_hi, 1'b0);
        check("R8 inverted lo", out_lo, 1'b1);
        fmask = 2'b01; fault = 1'b1; #1;
        check("R8 faulted inverted hi", out_hi, 1'b1);
        fault = 1'b0; fmask = 2'b00; inv = 2'b00; #1;
        check("R8 polarity restored", out_hi, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        step(2);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_bypass();
        t_ignore_b();
        t_rise(0);
        t_rise(1);
        t_rise(3);
        t_rise(7);
        t_rise(4095);
        t_fall(0);
        t_fall(1);
        t_fall(7);
        t_zero();
        t_short();
        t_fault();
        t_invert();
        finish_run();
    end

endmodule